// File: doc/BRIEF.md
# Edge Change Detection Interrupt Controller

This block watches a bank of digital input lines, organised as byte-wide ports, and raises an interrupt when a selected line makes a selected transition. Every line has two private enables, one for low-to-high and one for high-to-low changes. A global polarity gate in the control register can also switch off all rising or all falling detection at once. The first qualifying transition latches an edge flag. A further qualifying transition that arrives while that flag is still pending latches an overflow flag.

Software reaches the block through a byte-wide register port. Writes are synchronous and reads are combinational. Software reads the status byte, services the event, and then writes one-bits to a clear register to drop the flags. The interrupt line is the summary status bit. That bit depends on two levels of enable: a master enable and a per-cause enable for edge and for overflow.

Top module: `edge_change_irq`

## Requirements
- R1: After reset, the status (0x02), control (0x03) and all per-port enable registers read 0x00, and `irq_o` is low.
- R2: A read of address 0x00 returns the fixed identification byte given by parameter `ID_VALUE` (default 0xA5).
- R3: Port p (line `line_in[8p+i]` is bit i of port p) has its rising-enable byte at 0x42+0x10·p and its falling-enable byte at 0x43+0x10·p. Both are writable and read back unchanged.
- R4: A line that was 0 on the previous clock and is 1 now sets status bit 0 (edge flag) on that clock edge. This requires the line's rising-enable bit and control bit 3 (rising gate) to be set.
- R5: A line that was 1 on the previous clock and is 0 now sets status bit 0 on that clock edge. This requires the line's falling-enable bit and control bit 4 (falling gate) to be set.
- R6: A transition leaves the status unchanged in any of these cases: its line's enable for that polarity is clear, or the polarity gate in control bit 3 or bit 4 is clear.
- R7: Status bit 1 (overflow flag) sets when a qualifying transition occurs while the edge flag is already set and is not being cleared in that same cycle.
- R8: Writing address 0x01 clears the edge flag when data bit 3 is 1 and clears the overflow flag when data bit 2 is 1. Both may be cleared in one write. A qualifying transition in the same cycle as an edge clear leaves the edge flag set.
- R9: Status bit 2 equals control bit 2 AND ((edge flag AND control bit 0) OR (overflow flag AND control bit 1)), and `irq_o` always equals status bit 2.
- R10: The control register at 0x03 stores data bits 4:0, reads back with bits 7:5 as 0, and a write of 0x00 drops `irq_o` even while flags remain set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 32 | Monitored lines, port p in bits 8p+7:8p |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Interrupt request, equal to the master status bit |

## Verification
The assertions check the flag rules on every cycle. An overflow can only appear on top of a pending edge flag. A new edge flag always follows a detected event. A detected event always leaves the edge flag set, even against a clear. An unopposed clear always empties it. The interrupt is never raised without a pending flag or with the master enable off. Only the bench scenarios can show the address map, which line and polarity each enable bit governs, the effect of the polarity gates, and the full table of master-status combinations of control bits against flag states.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  localparam int DATA_W = 8;

  localparam logic [7:0] OFS_ID     = 8'h00;
  localparam logic [7:0] OFS_CLR    = 8'h01;
  localparam logic [7:0] OFS_STAT   = 8'h02;
  localparam logic [7:0] OFS_CTRL   = 8'h03;
  localparam logic [7:0] PORT_BASE  = 8'h40;
  localparam logic [7:0] PORT_STEP  = 8'h10;
  localparam logic [7:0] SUB_RISE   = 8'h02;
  localparam logic [7:0] SUB_FALL   = 8'h03;

  localparam int CLR_EDGE_BIT = 3;
  localparam int CLR_OVF_BIT  = 2;

  // control register layout, LSB last
  typedef struct packed {
    logic fall_gate;   // bit 4
    logic rise_gate;   // bit 3
    logic master;      // bit 2
    logic ovf_ie;      // bit 1
    logic edge_ie;     // bit 0
  } ctrl_t;

  function automatic logic [7:0] port_reg_addr(input int unsigned p, input logic [7:0] sub);
    return PORT_BASE + 8'(p) * PORT_STEP + sub;
  endfunction

  function automatic logic master_status(input logic edge_f, input logic ovf_f, input ctrl_t c);
    return c.master & ((edge_f & c.edge_ie) | (ovf_f & c.ovf_ie));
  endfunction

endpackage

// File: rtl/edge_sampler.sv
module edge_sampler #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] cur,
  input  logic [LINES-1:0] rise_mask,
  input  logic [LINES-1:0] fall_mask,
  input  logic             rise_gate,
  input  logic             fall_gate,
  output logic [LINES-1:0] rise_hit,
  output logic [LINES-1:0] fall_hit,
  output logic             evt_any
);

  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign rise_hit = cur & ~prev_q & rise_mask & {LINES{rise_gate}};
  assign fall_hit = ~cur & prev_q & fall_mask & {LINES{fall_gate}};
  assign evt_any  = (|rise_hit) | (|fall_hit);

endmodule

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs
  import edge_irq_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PW     = 8,
  localparam int LINES = NPORTS * PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  output logic [LINES-1:0] rise_mask,
  output logic [LINES-1:0] fall_mask,
  output ctrl_t            ctrl_q,
  output logic             clr_edge,
  output logic             clr_ovf
);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [PW-1:0] rise_r;
    logic [PW-1:0] fall_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rise_r <= '0;
        fall_r <= '0;
      end else if (we) begin
        if (addr == port_reg_addr(p, SUB_RISE)) rise_r <= wdata[PW-1:0];
        if (addr == port_reg_addr(p, SUB_FALL)) fall_r <= wdata[PW-1:0];
      end
    end
    assign rise_mask[p*PW +: PW] = rise_r;
    assign fall_mask[p*PW +: PW] = fall_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         ctrl_q <= '0;
    else if (we && addr == OFS_CTRL)    ctrl_q <= ctrl_t'(wdata[4:0]);
  end

  assign clr_edge = we && (addr == OFS_CLR) && wdata[CLR_EDGE_BIT];
  assign clr_ovf  = we && (addr == OFS_CLR) && wdata[CLR_OVF_BIT];

endmodule

// File: rtl/edge_flag_unit.sv
module edge_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr_edge,
  input  logic clr_ovf,
  output logic edge_q,
  output logic ovf_q
);

  logic ovf_set;

  // a second event counts only against a flag that survives this cycle
  assign ovf_set = evt & edge_q & ~clr_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      edge_q <= evt | (edge_q & ~clr_edge);
      ovf_q  <= ovf_set | (ovf_q & ~clr_ovf);
    end
  end

endmodule

// File: rtl/edge_change_irq.sv
module edge_change_irq
  import edge_irq_pkg::*;
#(
  parameter int         NPORTS   = 4,
  parameter int         PW       = 8,
  parameter logic [7:0] ID_VALUE = 8'hA5,
  localparam int        LINES    = NPORTS * PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  input  logic [7:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic             reg_we,
  output logic [7:0]       reg_rdata,
  output logic             irq_o
);

  logic [LINES-1:0] rise_mask, fall_mask, rise_hit, fall_hit;
  ctrl_t            ctrl_q;
  logic             clr_edge, clr_ovf, evt_any;
  logic             edge_flag, ovf_flag, mst_stat;

  edge_cfg_regs #(.NPORTS(NPORTS), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rise_mask(rise_mask), .fall_mask(fall_mask), .ctrl_q(ctrl_q),
    .clr_edge(clr_edge), .clr_ovf(clr_ovf)
  );

  edge_sampler #(.LINES(LINES)) u_samp (
    .clk(clk), .rst_n(rst_n), .cur(line_in),
    .rise_mask(rise_mask), .fall_mask(fall_mask),
    .rise_gate(ctrl_q.rise_gate), .fall_gate(ctrl_q.fall_gate),
    .rise_hit(rise_hit), .fall_hit(fall_hit), .evt_any(evt_any)
  );

  edge_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_any),
    .clr_edge(clr_edge), .clr_ovf(clr_ovf),
    .edge_q(edge_flag), .ovf_q(ovf_flag)
  );

  assign mst_stat = master_status(edge_flag, ovf_flag, ctrl_q);
  assign irq_o    = mst_stat;

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == OFS_ID)   reg_rdata = ID_VALUE;
    if (reg_addr == OFS_STAT) reg_rdata = {5'b0, mst_stat, ovf_flag, edge_flag};
    if (reg_addr == OFS_CTRL) reg_rdata = {3'b0, ctrl_q};
    for (int p = 0; p < NPORTS; p++) begin
      if (reg_addr == port_reg_addr(p, SUB_RISE)) reg_rdata[PW-1:0] = rise_mask[p*PW +: PW];
      if (reg_addr == port_reg_addr(p, SUB_FALL)) reg_rdata[PW-1:0] = fall_mask[p*PW +: PW];
    end
  end

endmodule

// File: rtl/edge_irq_checker.sv
module edge_irq_checker (
  input logic clk,
  input logic rst_n,
  input logic evt_any,
  input logic edge_flag,
  input logic ovf_flag,
  input logic clr_edge,
  input logic master_en,
  input logic irq
);

  assert_ovf_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(edge_flag));

  assert_edge_from_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_flag) |-> $past(evt_any));

  assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any |=> edge_flag);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !evt_any) |=> !edge_flag);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (edge_flag || ovf_flag));

  assert_irq_needs_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> !irq);

endmodule

bind edge_change_irq edge_irq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .evt_any(evt_any), .edge_flag(edge_flag),
  .ovf_flag(ovf_flag), .clr_edge(clr_edge), .master_en(ctrl_q.master), .irq(irq_o)
);

// File: tb/sim_edge_change_irq.sv
`timescale 1ns/1ps
module sim_edge_change_irq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] line_in = '0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_rdata;
  logic        irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  edge_change_irq u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    line_in = v;
    @(negedge clk);
  endtask

  function automatic logic [7:0] rise_adr(input int p); return 8'h42 + 8'(p) * 8'h10; endfunction
  function automatic logic [7:0] fall_adr(input int p); return 8'h43 + 8'(p) * 8'h10; endfunction
  function automatic logic exp_mst(input logic [4:0] c, input logic e, input logic o);
    return c[2] & ((e & c[0]) | (o & c[1]));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h02, d); chk("R1 status", d, 8'h00);
    rd(8'h03, d); chk("R1 ctrl", d, 8'h00);
    for (int p = 0; p < 4; p++) begin
      rd(rise_adr(p), d); chk("R1 rise en", d, 8'h00);
      rd(fall_adr(p), d); chk("R1 fall en", d, 8'h00);
    end
    chk("R1 irq", {7'b0, irq_o}, 8'h00);

    // R2 identification byte
    rd(8'h00, d); chk("R2 id", d, 8'hA5);

    // R3 enable register map
    for (int p = 0; p < 4; p++) begin
      wr(rise_adr(p), 8'h3C ^ 8'(p * 17));
      wr(fall_adr(p), 8'hC1 ^ 8'(p * 29));
    end
    for (int p = 0; p < 4; p++) begin
      rd(rise_adr(p), d); chk("R3 rise readback", d, 8'h3C ^ 8'(p * 17));
      rd(fall_adr(p), d); chk("R3 fall readback", d, 8'hC1 ^ 8'(p * 29));
    end
    for (int p = 0; p < 4; p++) begin
      wr(rise_adr(p), 8'h00); wr(fall_adr(p), 8'h00);
    end

    // R4 / R5 / R6 sweep over every line and both polarities
    wr(8'h03, 8'h18);
    for (int i = 0; i < 32; i++) begin
      wr(rise_adr(i / 8), 8'(1 << (i % 8)));
      drive(32'(1) << i);
      rd(8'h02, d); chk("R4 rising line", d, 8'h01);
      drive(32'h0);
      rd(8'h02, d); chk("R6 falling not enabled", d, 8'h01);
      wr(8'h01, 8'h0C);
      wr(rise_adr(i / 8), 8'h00);
      wr(fall_adr(i / 8), 8'(1 << (i % 8)));
      drive(32'(1) << i);
      rd(8'h02, d); chk("R6 rising not enabled", d, 8'h00);
      drive(32'h0);
      rd(8'h02, d); chk("R5 falling line", d, 8'h01);
      wr(8'h01, 8'h0C);
      wr(fall_adr(i / 8), 8'h00);
    end

    // R6 other lines toggle, and polarity gate off
    wr(rise_adr(0), 8'h20); wr(fall_adr(0), 8'h20);
    drive(32'hFFFF_FFDF);
    drive(32'h0);
    rd(8'h02, d); chk("R6 unrelated lines", d, 8'h00);
    wr(8'h03, 8'h10);
    drive(32'h20);
    rd(8'h02, d); chk("R6 rise gate off", d, 8'h00);
    wr(8'h03, 8'h08);
    drive(32'h0);
    rd(8'h02, d); chk("R6 fall gate off", d, 8'h00);
    wr(8'h03, 8'h18);

    // R7 overflow and R8 selective clears
    drive(32'h20);
    rd(8'h02, d); chk("R7 first event", d, 8'h01);
    drive(32'h0);
    rd(8'h02, d); chk("R7 overflow", d, 8'h03);
    wr(8'h01, 8'h08);
    rd(8'h02, d); chk("R8 clear edge only", d, 8'h02);
    wr(8'h01, 8'h04);
    rd(8'h02, d); chk("R8 clear ovf", d, 8'h00);
    drive(32'h20);
    drive(32'h0);
    wr(8'h01, 8'h0C);
    rd(8'h02, d); chk("R8 clear both", d, 8'h00);

    // R8 event in the same cycle as a clear
    drive(32'h20);
    @(negedge clk);
    line_in = 32'h0; reg_we = 1'b1; reg_addr = 8'h01; reg_wdata = 8'h0C;
    @(negedge clk);
    reg_we = 1'b0;
    rd(8'h02, d); chk("R8 event wins over clear", d, 8'h01);
    wr(8'h01, 8'h0C);

    // R9 master status across control bits and flag states
    for (int s = 1; s < 4; s++) begin
      logic e, o;
      e = s[0]; o = s[1];
      wr(8'h03, 8'h18);
      wr(8'h01, 8'h0C);
      if (o) begin drive(32'h20); drive(32'h0); end
      else   begin drive(32'h20); end
      if (!e) wr(8'h01, 8'h08);
      for (int c = 0; c < 8; c++) begin
        logic [4:0] cv;
        cv = 5'(c) | 5'h18;
        wr(8'h03, {3'b0, cv});
        rd(8'h02, d);
        chk("R9 status", d, {5'b0, exp_mst(cv, e, o), o, e});
        chk("R9 irq", {7'b0, irq_o}, {7'b0, exp_mst(cv, e, o)});
      end
      line_in = 32'h0;
    end

    // R10 control readback and disable
    wr(8'h03, 8'hFF);
    rd(8'h03, d); chk("R10 ctrl readback", d, 8'h1F);
    chk("R10 irq on", {7'b0, irq_o}, 8'h01);
    wr(8'h03, 8'h00);
    rd(8'h03, d); chk("R10 ctrl zero", d, 8'h00);
    chk("R10 irq off", {7'b0, irq_o}, 8'h00);
    rd(8'h02, d); chk("R10 flags kept", d, 8'h03);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule